// File: doc/BRIEF.md
# Ethernet Frame Header Classifier

This block watches a raw Ethernet frame that arrives one byte per clock on a valid/last stream, starting with the first preamble byte. It checks the preamble and the start delimiter, then collects the destination address, the source address and the length/type field. When the last byte arrives it reports the frame's classification on a single-cycle done strobe. The reported fields are: group or individual destination, type or length meaning of the length/type field, an IPv4 marker, and a short or long frame indication. Framing faults are reported on the same strobe.

The bytes that follow the start delimiter are forwarded on an output stream, held back four bytes so the trailing check sequence can be dropped. A region flag travels with each forwarded byte and marks the payload, meaning everything after the length/type field. Check sequence verification, control frames and tagged frames are handled elsewhere.

Top module: `eth_frame_sorter`

## Requirements
- R1: The frame must start with exactly 7 bytes of 0x55 and then a delimiter byte of 0xD5. A wrong preamble byte or a wrong delimiter sends the block into a discard state until a byte with inLast. A frame whose inLast comes before the delimiter is accepted also counts as broken. For a broken frame the done strobe carries framingErr=1 with isGroup, isType, isIpv4, isRunt and isOversize all 0, and no byte is forwarded.
- R2: doneStrobe is high for exactly the one cycle after each accepted byte that has inLast set, and at no other time.
- R3: dstAddr, srcAddr and lenType are assembled most significant byte first. The first destination byte lands in dstAddr[47:40], the first source byte in srcAddr[47:40], and the first length/type byte in lenType[15:8].
- R4: isGroup equals bit 0 of the first destination address byte. That bit is 1 for a group address and 0 for an individual address.
- R5: isType is 1 when the length/type value is 1536 (0x0600) or more. It is 0 for smaller values, which give the data length.
- R6: isIpv4 is 1 exactly when the length/type value equals 0x0800.
- R7: The frame length is counted from the first destination byte through the last byte, and includes the 4 check bytes. isRunt is 1 when this length is below 64. isOversize is 1 when it is above 1518.
- R8: Every byte after the delimiter, except the final 4, is forwarded in arrival order on outData with outValid. A byte is forwarded one cycle after the byte four positions later is accepted. The final 4 bytes are never forwarded.
- R9: dataRegion is 1 on a forwarded byte exactly when that byte's index after the delimiter is 14 or more. Index 0 is the first destination byte.
- R10: After reset, outValid, dataRegion, doneStrobe, framingErr and all classification flags are 0.
- R11: Cycles with inValid low are ignored anywhere in the frame and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte is present |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Input byte is the final byte of the frame |
| outValid | output | 1 | Forwarded byte is present |
| outData | output | 8 | Forwarded byte |
| dataRegion | output | 1 | Forwarded byte lies in the payload |
| doneStrobe | output | 1 | One-cycle frame result strobe |
| framingErr | output | 1 | Preamble or delimiter fault |
| dstAddr | output | 48 | Destination address |
| srcAddr | output | 48 | Source address |
| lenType | output | 16 | Length/type value |
| isGroup | output | 1 | Group destination address |
| isType | output | 1 | Length/type holds a type |
| isIpv4 | output | 1 | Type is IPv4 |
| isRunt | output | 1 | Frame shorter than 64 bytes |
| isOversize | output | 1 | Frame longer than 1518 bytes |

## Verification
The hardest situations to reach are the length boundaries, because a frame has to be 63, 64, 1518 or 1519 bytes long exactly, and the framing faults at each single preamble position. The bench builds every frame from a length, a first address byte, a length/type value, an optional corrupted position and an optional cut-off point. It then sweeps lengths around both limits, every preamble position, the delimiter, and a set of length/type values around the 1536 cut and at 0x0800. Idle gaps are inserted into one frame to show that they change nothing.

// File: rtl/eth_sorter_pkg.sv
package eth_sorter_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic bodyByte;
    logic capDst;
    logic capSrc;
    logic capLen;
    logic payCand;
    logic frameEnd;
    logic badFrame;
    logic lenRunt;
    logic lenOver;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_PRE,
    ST_SFD,
    ST_BODY,
    ST_DROP
  } sortState_t;
endpackage

// File: rtl/eth_sorter_ctrl.sv
module eth_sorter_ctrl
  import eth_sorter_pkg::*;
#(
  parameter int PreLen = 7,
  parameter int AddrLen = 6,
  parameter int MinLen = 64,
  parameter int MaxLen = 1518,
  parameter logic [7:0] PreByte = 8'h55,
  parameter logic [7:0] SfdByte = 8'hD5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [7:0]   inData,
  input  logic         inLast,
  output ctrlStrobes_t st
);
  localparam int CntW = $clog2(MaxLen + 1);
  localparam int PreW = (PreLen > 1) ? $clog2(PreLen) : 1;
  localparam logic [CntW-1:0] SrcStart = CntW'(AddrLen);
  localparam logic [CntW-1:0] LenStart = CntW'(2 * AddrLen);
  localparam logic [CntW-1:0] PayStart = CntW'(2 * AddrLen + 2);
  localparam logic [CntW-1:0] CntSat   = CntW'(MaxLen);
  localparam logic [CntW:0]   MinLenV  = (CntW + 1)'(MinLen);
  localparam logic [CntW:0]   MaxLenV  = (CntW + 1)'(MaxLen);
  localparam logic [PreW-1:0] PreEnd   = PreW'(PreLen - 1);

  sortState_t state;
  logic [PreW-1:0] preCnt;
  logic [CntW-1:0] bodyCnt;
  logic [CntW:0]   frameLen;

  assign frameLen = {1'b0, bodyCnt} + 1'b1;

  always_comb begin
    st = '0;
    if (inValid) begin
      if (state == ST_BODY) begin
        st.bodyByte = 1'b1;
        st.capDst   = bodyCnt < SrcStart;
        st.capSrc   = (bodyCnt >= SrcStart) && (bodyCnt < LenStart);
        st.capLen   = (bodyCnt >= LenStart) && (bodyCnt < PayStart);
        st.payCand  = bodyCnt >= PayStart;
      end
      if (inLast) begin
        st.frameEnd = 1'b1;
        st.badFrame = state != ST_BODY;
        st.lenRunt  = (state == ST_BODY) && (frameLen < MinLenV);
        st.lenOver  = (state == ST_BODY) && (frameLen > MaxLenV);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PRE;
      preCnt  <= '0;
      bodyCnt <= '0;
    end else if (inValid) begin
      if (inLast) begin
        state   <= ST_PRE;
        preCnt  <= '0;
        bodyCnt <= '0;
      end else begin
        case (state)
          ST_PRE: begin
            if (inData != PreByte) state <= ST_DROP;
            else if (preCnt == PreEnd) state <= ST_SFD;
            else preCnt <= preCnt + 1'b1;
          end
          ST_SFD:  state <= (inData == SfdByte) ? ST_BODY : ST_DROP;
          ST_BODY: if (bodyCnt != CntSat) bodyCnt <= bodyCnt + 1'b1;
          default: state <= ST_DROP;
        endcase
      end
    end
  end
endmodule

// File: rtl/eth_sorter_dp.sv
module eth_sorter_dp
  import eth_sorter_pkg::*;
#(
  parameter int HoldLen = 4,
  parameter logic [15:0] TypeMin = 16'd1536,
  parameter logic [15:0] Ipv4Code = 16'h0800
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   inData,
  input  ctrlStrobes_t st,
  output logic         outValid,
  output logic [7:0]   outData,
  output logic         dataRegion,
  output logic         doneStrobe,
  output logic         framingErr,
  output logic [47:0]  dstAddr,
  output logic [47:0]  srcAddr,
  output logic [15:0]  lenType,
  output logic         isGroup,
  output logic         isType,
  output logic         isIpv4,
  output logic         isRunt,
  output logic         isOversize
);
  logic [7:0] dlyData [HoldLen];
  logic       dlyCand [HoldLen];
  logic       dlyVld  [HoldLen];
  logic [47:0] dstNext;
  logic [15:0] lenNext;

  assign dstNext = st.capDst ? {dstAddr[39:0], inData} : dstAddr;
  assign lenNext = st.capLen ? {lenType[7:0], inData} : lenType;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstAddr <= '0;
      srcAddr <= '0;
      lenType <= '0;
    end else begin
      dstAddr <= dstNext;
      lenType <= lenNext;
      if (st.capSrc) srcAddr <= {srcAddr[39:0], inData};
    end
  end

  // first hold-back stage
  always_ff @(posedge clk) begin
    if (!rstN || st.frameEnd) begin
      dlyVld[0] <= 1'b0;
    end else if (st.bodyByte) begin
      dlyVld[0] <= 1'b1;
    end
    if (st.bodyByte) begin
      dlyData[0] <= inData;
      dlyCand[0] <= st.payCand;
    end
  end

  for (genvar g = 1; g < HoldLen; g++) begin : gHold
    always_ff @(posedge clk) begin
      if (!rstN || st.frameEnd) begin
        dlyVld[g] <= 1'b0;
      end else if (st.bodyByte) begin
        dlyVld[g] <= dlyVld[g-1];
      end
      if (st.bodyByte) begin
        dlyData[g] <= dlyData[g-1];
        dlyCand[g] <= dlyCand[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      dataRegion <= 1'b0;
    end else begin
      outValid   <= st.bodyByte && dlyVld[HoldLen-1];
      dataRegion <= st.bodyByte && dlyVld[HoldLen-1] && dlyCand[HoldLen-1];
      if (st.bodyByte) outData <= dlyData[HoldLen-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStrobe <= 1'b0;
      framingErr <= 1'b0;
      isGroup    <= 1'b0;
      isType     <= 1'b0;
      isIpv4     <= 1'b0;
      isRunt     <= 1'b0;
      isOversize <= 1'b0;
    end else begin
      doneStrobe <= st.frameEnd;
      if (st.frameEnd) begin
        framingErr <= st.badFrame;
        isGroup    <= !st.badFrame && dstNext[40];
        isType     <= !st.badFrame && (lenNext >= TypeMin);
        isIpv4     <= !st.badFrame && (lenNext == Ipv4Code);
        isRunt     <= st.lenRunt;
        isOversize <= st.lenOver;
      end
    end
  end
endmodule

// File: rtl/eth_frame_sorter.sv
module eth_frame_sorter
  import eth_sorter_pkg::*;
#(
  parameter int PreLen = 7,
  parameter int AddrLen = 6,
  parameter int HoldLen = 4,
  parameter int MinLen = 64,
  parameter int MaxLen = 1518,
  parameter logic [15:0] TypeMin = 16'd1536,
  parameter logic [15:0] Ipv4Code = 16'h0800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        dataRegion,
  output logic        doneStrobe,
  output logic        framingErr,
  output logic [47:0] dstAddr,
  output logic [47:0] srcAddr,
  output logic [15:0] lenType,
  output logic        isGroup,
  output logic        isType,
  output logic        isIpv4,
  output logic        isRunt,
  output logic        isOversize
);
  ctrlStrobes_t st;

  eth_sorter_ctrl #(
    .PreLen(PreLen), .AddrLen(AddrLen), .MinLen(MinLen), .MaxLen(MaxLen)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inLast(inLast), .st(st)
  );

  eth_sorter_dp #(
    .HoldLen(HoldLen), .TypeMin(TypeMin), .Ipv4Code(Ipv4Code)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .st(st),
    .outValid(outValid), .outData(outData), .dataRegion(dataRegion),
    .doneStrobe(doneStrobe), .framingErr(framingErr),
    .dstAddr(dstAddr), .srcAddr(srcAddr), .lenType(lenType),
    .isGroup(isGroup), .isType(isType), .isIpv4(isIpv4),
    .isRunt(isRunt), .isOversize(isOversize)
  );
endmodule

// File: rtl/eth_frame_sorter_chk.sv
module eth_frame_sorter_chk #(
  parameter logic [15:0] TypeMin = 16'd1536,
  parameter logic [15:0] Ipv4Code = 16'h0800
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inLast,
  input logic        outValid,
  input logic        dataRegion,
  input logic        doneStrobe,
  input logic        framingErr,
  input logic [15:0] lenType,
  input logic        isGroup,
  input logic        isType,
  input logic        isIpv4,
  input logic        isRunt,
  input logic        isOversize
);
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> doneStrobe);

  p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inLast) |=> !doneStrobe);

  p_err_clears_flags_r1: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && framingErr) |-> !(isGroup || isType || isIpv4 || isRunt || isOversize));

  p_ipv4_is_type_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && isIpv4) |-> (isType && lenType == Ipv4Code));

  p_type_cut_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && !framingErr) |-> (isType == (lenType >= TypeMin)));

  p_len_flags_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(isRunt && isOversize));

  p_region_in_stream_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataRegion |-> outValid);

  p_out_needs_input_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
endmodule

bind eth_frame_sorter eth_frame_sorter_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
  .outValid(outValid), .dataRegion(dataRegion), .doneStrobe(doneStrobe),
  .framingErr(framingErr), .lenType(lenType), .isGroup(isGroup),
  .isType(isType), .isIpv4(isIpv4), .isRunt(isRunt), .isOversize(isOversize)
);

// File: tb/test_eth_frame_sorter.sv
module test_eth_frame_sorter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;
  logic outValid, dataRegion, doneStrobe, framingErr;
  logic [7:0] outData;
  logic [47:0] dstAddr, srcAddr;
  logic [15:0] lenType;
  logic isGroup, isType, isIpv4, isRunt, isOversize;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  eth_frame_sorter i_eth_frame_sorter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outData(outData), .dataRegion(dataRegion),
    .doneStrobe(doneStrobe), .framingErr(framingErr), .dstAddr(dstAddr),
    .srcAddr(srcAddr), .lenType(lenType), .isGroup(isGroup), .isType(isType),
    .isIpv4(isIpv4), .isRunt(isRunt), .isOversize(isOversize)
  );

  // monitor, sampled away from the active edge
  logic [7:0] gotData [0:1700];
  logic       gotReg  [0:1700];
  int gotN = 0;
  int doneN = 0;
  logic sErr, sGrp, sTyp, sIp4, sRunt, sOver;
  logic [47:0] sDst, sSrc;
  logic [15:0] sLen;

  always @(negedge clk) begin
    if (outValid) begin
      gotData[gotN] = outData;
      gotReg[gotN] = dataRegion;
      gotN++;
    end
    if (doneStrobe) begin
      doneN++;
      sErr = framingErr; sGrp = isGroup; sTyp = isType; sIp4 = isIpv4;
      sRunt = isRunt; sOver = isOversize; sDst = dstAddr; sSrc = srcAddr; sLen = lenType;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] body [0:1700];

  function automatic logic [7:0] bodyByte(int i, logic [7:0] da0, logic [15:0] lt);
    if (i == 0) return da0;
    if (i < 6) return 8'(8'h10 + i);
    if (i < 12) return 8'(8'hA0 + i);
    if (i == 12) return lt[15:8];
    if (i == 13) return lt[7:0];
    return 8'((i * 13 + 5) & 255);
  endfunction

  // badPos: -1 none, 0..6 preamble byte, 7 delimiter; cutAt: >0 stops the stream after that many bytes
  task automatic sendFrame(input int len, input logic [7:0] da0, input logic [15:0] lt,
                           input int badPos, input int cutAt, input int gapEvery);
    int total;
    logic good;
    logic [47:0] eDst, eSrc;
    int eN;
    logic dOk, rOk;
    total = (cutAt > 0) ? cutAt : len + 8;
    good = (badPos < 0) && (cutAt == 0);
    for (int i = 0; i < len; i++) body[i] = bodyByte(i, da0, lt);
    gotN = 0;
    doneN = 0;
    for (int k = 0; k < total; k++) begin
      logic [7:0] b;
      if (k < 7) b = 8'h55;
      else if (k == 7) b = 8'hD5;
      else b = body[k-8];
      if (k == badPos) b = (k == 7) ? 8'h55 : 8'h54;
      if (gapEvery > 0 && (k % gapEvery) == 1) begin
        @(negedge clk);
        inValid = 1'b0;
        inData = 8'hEE;
        inLast = 1'b1;
        @(negedge clk);
        inLast = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1;
      inData = b;
      inLast = (k == total - 1);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R2: exactly one done strobe per frame
    check(doneN == 1, "R2 done count", doneN, 1);
    check(sErr == !good, "R1 framingErr", sErr, !good);
    if (!good) begin
      check(gotN == 0, "R1 no bytes forwarded on broken frame", gotN, 0);
      check({sGrp, sTyp, sIp4, sRunt, sOver} == 5'b0, "R1 flags cleared",
            {sGrp, sTyp, sIp4, sRunt, sOver}, 0);
    end else begin
      eN = (len > 4) ? len - 4 : 0;
      check(gotN == eN, "R8 forwarded count", gotN, eN);
      dOk = 1'b1;
      rOk = 1'b1;
      for (int j = 0; j < gotN && j < eN; j++) begin
        if (gotData[j] != body[j]) dOk = 1'b0;
        if (gotReg[j] != (j >= 14)) rOk = 1'b0;
      end
      check(dOk, "R8 forwarded bytes", dOk, 1);
      check(rOk, "R9 payload region", rOk, 1);
      check(sRunt == (len < 64), "R7 runt", sRunt, len < 64);
      check(sOver == (len > 1518), "R7 oversize", sOver, len > 1518);
      if (len >= 14) begin
        eDst = {da0, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15};
        eSrc = {8'hA6, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB};
        check(sDst == eDst, "R3 dstAddr", sDst, eDst);
        check(sSrc == eSrc, "R3 srcAddr", sSrc, eSrc);
        check(sLen == lt, "R3 lenType", sLen, lt);
        check(sGrp == da0[0], "R4 group bit", sGrp, da0[0]);
        check(sTyp == (lt >= 16'd1536), "R5 type cut", sTyp, lt >= 16'd1536);
        check(sIp4 == (lt == 16'h0800), "R6 ipv4", sIp4, lt == 16'h0800);
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    summary();
    $finish;
  end

  logic [15:0] ltList [0:7];
  logic [7:0]  daList [0:5];

  initial begin
    ltList[0] = 16'h0000; ltList[1] = 16'h002E; ltList[2] = 16'h05DC; ltList[3] = 16'h05FF;
    ltList[4] = 16'h0600; ltList[5] = 16'h0800; ltList[6] = 16'h0801; ltList[7] = 16'h86DD;
    daList[0] = 8'h00; daList[1] = 8'h01; daList[2] = 8'h02;
    daList[3] = 8'h03; daList[4] = 8'hFE; daList[5] = 8'hFF;
    repeat (3) @(negedge clk);
    // R10: quiet outputs in reset and right after
    check({outValid, dataRegion, doneStrobe, framingErr} == 4'b0, "R10 reset outputs",
          {outValid, dataRegion, doneStrobe, framingErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({isGroup, isType, isIpv4, isRunt, isOversize} == 5'b0, "R10 reset flags",
          {isGroup, isType, isIpv4, isRunt, isOversize}, 0);
    // R5 R6: length/type sweep
    for (int t = 0; t < 8; t++) sendFrame(64, 8'h00, ltList[t], -1, 0, 0);
    // R4: group bit sweep
    for (int d = 0; d < 6; d++) sendFrame(70, daList[d], 16'h0800, -1, 0, 0);
    // R7: lengths around both limits, plus tiny frames
    for (int n = 60; n <= 66; n++) sendFrame(n, 8'h01, 16'h0600, -1, 0, 0);
    for (int n = 1516; n <= 1521; n++) sendFrame(n, 8'h00, 16'h05DC, -1, 0, 0);
    sendFrame(4, 8'h00, 16'h0000, -1, 0, 0);
    sendFrame(10, 8'h00, 16'h0000, -1, 0, 0);
    // R1: corrupt each preamble position and the delimiter, then a clean frame
    for (int p = 0; p <= 7; p++) begin
      sendFrame(64, 8'h01, 16'h0800, p, 0, 0);
      sendFrame(64, 8'h01, 16'h0800, -1, 0, 0);
    end
    // R1: stream cut before the delimiter is accepted
    sendFrame(64, 8'h00, 16'h0800, -1, 3, 0);
    sendFrame(64, 8'h00, 16'h0800, -1, 8, 0);
    // R11: idle gaps with junk on the inputs
    sendFrame(80, 8'h03, 16'h0800, -1, 0, 5);
    summary();
    $finish;
  end
endmodule